// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation miss in hardware. Given a 64-bit virtual address, a root table frame and the access type (read or write, user or kernel), it reads a forward-mapped table of three levels from memory. It makes one read per level through a plain request/response port, and it returns the physical frame number and the permission bits of the leaf entry. If an entry is invalid, or if the leaf does not allow the requested access, it raises a fault instead.

Before any walk, the two top address bits select a region. A clear top bit selects the user code/heap region. Both top bits set selects the user stack region. Both of these are walked. Top bits `10` select the kernel window, which maps straight onto physical memory from the low address bits and needs no memory read. Pages are 8 KB and each entry is 8 bytes, so one table (1024 entries) fills exactly one page. Only the low 43 address bits take part in the translation.

The walker accepts one request at a time. `busy` rises on acceptance and stays high through the cycle in which `done` or `fault` pulses.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held, `busy`, `done`, `fault` and `mem_req_valid` are all low.
- R2: `res_region` reports the region of the last request: 0 when bit 63 is 0 (user code/heap), 1 when bits 63:62 are `11` (user stack), 2 when bits 63:62 are `10` (kernel window).
- R3: A kernel-window request in kernel mode produces `done` in the cycle after acceptance, with no memory read, `res_pfn` = address bits 39:13 and `res_perm` = `4'b0011`. A kernel-window request in user mode instead pulses `fault` in that cycle, with `fault_perm`=1 and `fault_level`=0.
- R4: The index for level n (n = 0, 1, 2) is address bits [42-10n : 33-10n]. The read address is {table frame, index, 3'b000}. The level 0 table frame is `req_root`, and each later table frame is the frame field of the entry read one level above.
- R5: A user or stack walk issues exactly one read per level it reaches, so a walk that ends at the leaf issues three. `mem_req_valid` is a single-cycle pulse and is never raised again before the response to the previous read.
- R6: An entry whose valid bit (bit 0) is clear, at level n, ends the walk with a `fault` pulse, `fault_perm`=0 and `fault_level`=n. No further reads follow.
- R7: Entry bits are: 1 kernel read, 2 kernel write, 3 user read, 4 user write, and 58:32 the frame number. The leaf entry must grant the bit that matches the request's mode and type. If it does not, the walk faults with `fault_perm`=1 and `fault_level`=2. The permission bits of the upper levels are not consulted.
- R8: A walk that passes pulses `done` for one cycle, never together with `fault`. It returns the leaf frame in `res_pfn` and entry bits 4:1 in `res_perm` (order {UW,UR,KW,KR}).
- R9: `busy` is high from the cycle after acceptance up to and including the `done`/`fault` cycle, and low in the cycle after that. A `req_valid` raised while busy is ignored.
- R10: Address bits 61:43 have no effect on the region decode, the read addresses or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 27 | Frame number of the level 0 table |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel-mode access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | One-cycle read request to memory |
| mem_req_addr | output | 40 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: access violation |
| fault_perm | output | 1 | 1 = permission failure, 0 = invalid entry |
| fault_level | output | 2 | Level at which the fault was found |
| res_pfn | output | 27 | Translated frame number |
| res_perm | output | 4 | Leaf permission bits {UW,UR,KW,KR} |
| res_region | output | 2 | Region code of the last request |

## Verification
The checker assumes a memory that takes every request at once and returns exactly one response, at least one cycle later, only while the walker is waiting. It also assumes the requester does not depend on a request raised during a walk being taken. The bench memory model keeps to this: it answers each read once after a set latency of one to three cycles. The only requests the bench raises while busy are deliberate probes, placed in cycles where the walker is waiting on memory. The sweeps cover every leaf permission pattern under all four mode/type pairs, an invalid entry at each level, and kernel-window requests in both modes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    RG_USER   = 2'd0,
    RG_STACK  = 2'd1,
    RG_KERNEL = 2'd2
  } region_e;

  // Entry field positions
  localparam int PTE_V       = 0;
  localparam int PTE_PERM_LO = 1;   // bits 4:1 = {UW,UR,KW,KR}
  localparam int PTE_PERM_W  = 4;
  localparam int PTE_PFN_LSB = 32;

endpackage

// File: rtl/ptw_region.sv
module ptw_region
  import ptw_pkg::*;
(
  input  logic [1:0] top_bits,
  output region_e    region
);
  always_comb begin
    if (!top_bits[1])      region = RG_USER;
    else if (top_bits[0])  region = RG_STACK;
    else                   region = RG_KERNEL;
  end
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3
) (
  input  logic [LEVELS*IDX_W-1:0]          vpn,
  output logic [LEVELS-1:0][IDX_W-1:0]     idx
);
  // Level 0 takes the most significant field
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign idx[l] = vpn[(LEVELS-1-l)*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm (
  input  logic [3:0] perm,   // {UW,UR,KW,KR}
  input  logic       user,
  input  logic       write,
  output logic       ok
);
  always_comb begin
    case ({user, write})
      2'b00:   ok = perm[0];
      2'b01:   ok = perm[1];
      2'b10:   ok = perm[2];
      default: ok = perm[3];
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3,
  parameter int PTE_W  = 64,
  localparam int OFF_W = IDX_W + 3,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int SIG_W = OFF_W + VPN_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PFN_W-1:0] req_root,
  input  logic             req_user,
  input  logic             req_write,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic             fault_perm,
  output logic [LVL_W-1:0] fault_level,
  output logic [PFN_W-1:0] res_pfn,
  output logic [3:0]       res_perm,
  output logic [1:0]       res_region
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PFN_W-1:0] base_q, base_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic             user_q, user_d, write_q, write_d;
  region_e          region_q, region_d, req_region;
  logic [PFN_W-1:0] pfn_q, pfn_d;
  logic [3:0]       perm_q, perm_d;
  logic             fperm_q, fperm_d;
  logic [LVL_W-1:0] flvl_q, flvl_d;
  logic             ctx_en, res_en;

  logic [LEVELS-1:0][IDX_W-1:0] idx_all;
  logic [PFN_W-1:0] rsp_pfn;
  logic [3:0]       rsp_perm;
  logic             rsp_ok;

  logic unused_va_bits;
  logic unused_rsp_bits;
  assign unused_va_bits  = ^req_va[VA_W-3:SIG_W];
  assign unused_rsp_bits = ^{mem_rsp_data[PTE_W-1:PTE_PFN_LSB+PFN_W],
                             mem_rsp_data[PTE_PFN_LSB-1:PTE_PERM_LO+PTE_PERM_W]};

  ptw_region u_region (
    .top_bits (req_va[VA_W-1 -: 2]),
    .region   (req_region)
  );

  ptw_index #(.IDX_W(IDX_W), .LEVELS(LEVELS)) u_index (
    .vpn (vpn_q),
    .idx (idx_all)
  );

  assign rsp_pfn  = mem_rsp_data[PTE_PFN_LSB +: PFN_W];
  assign rsp_perm = mem_rsp_data[PTE_PERM_LO +: PTE_PERM_W];

  ptw_perm u_perm (
    .perm  (rsp_perm),
    .user  (user_q),
    .write (write_q),
    .ok    (rsp_ok)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    lvl_d    = lvl_q;
    base_d   = base_q;
    vpn_d    = vpn_q;
    user_d   = user_q;
    write_d  = write_q;
    region_d = region_q;
    pfn_d    = pfn_q;
    perm_d   = perm_q;
    fperm_d  = fperm_q;
    flvl_d   = flvl_q;
    ctx_en   = 1'b0;
    res_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ctx_en   = 1'b1;
          res_en   = 1'b1;
          vpn_d    = req_va[SIG_W-1:OFF_W];
          user_d   = req_user;
          write_d  = req_write;
          region_d = req_region;
          base_d   = req_root;
          lvl_d    = '0;
          if (req_region == RG_KERNEL) begin
            pfn_d  = req_va[PA_W-1:OFF_W];
            perm_d = 4'b0011;
            if (req_user) begin
              fperm_d = 1'b1;
              flvl_d  = '0;
              state_d = ST_FAULT;
            end else begin
              state_d = ST_DONE;
            end
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          ctx_en = 1'b1;
          if (!mem_rsp_data[PTE_V]) begin
            res_en  = 1'b1;
            fperm_d = 1'b0;
            flvl_d  = lvl_q;
            state_d = ST_FAULT;
          end else if (lvl_q == LAST_LVL) begin
            res_en  = 1'b1;
            pfn_d   = rsp_pfn;
            perm_d  = rsp_perm;
            fperm_d = 1'b1;
            flvl_d  = lvl_q;
            state_d = rsp_ok ? ST_DONE : ST_FAULT;
          end else begin
            base_d  = rsp_pfn;
            lvl_d   = lvl_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      base_q  <= '0;
      vpn_q   <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (ctx_en) begin
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      vpn_q   <= vpn_d;
      user_q  <= user_d;
      write_q <= write_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= RG_USER;
      pfn_q    <= '0;
      perm_q   <= '0;
      fperm_q  <= 1'b0;
      flvl_q   <= '0;
    end else if (res_en) begin
      region_q <= region_d;
      pfn_q    <= pfn_d;
      perm_q   <= perm_d;
      fperm_q  <= fperm_d;
      flvl_q   <= flvl_d;
    end
  end

  // Outputs
  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = {base_q, idx_all[lvl_q], 3'b000};
  assign done          = (state_q == ST_DONE);
  assign fault         = (state_q == ST_FAULT);
  assign fault_perm    = fperm_q;
  assign fault_level   = flvl_q;
  assign res_pfn       = pfn_q;
  assign res_perm      = perm_q;
  assign res_region    = region_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W   = 64,
  parameter int LVL_W  = 2,
  parameter int LEVELS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_rsp_valid,
  input logic             done,
  input logic             fault,
  input logic [LVL_W-1:0] fault_level
);

  AST_MEM_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);  // R5

  AST_MEM_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);  // R5

  AST_NO_REQ_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);  // R5

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));  // R8

  AST_END_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);  // R9

  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy);  // R9

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);  // R9

  AST_KERNEL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_va[VA_W-1 -: 2] == 2'b10)
      |=> ((done || fault) && !mem_req_valid));  // R3

  AST_FAULT_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (int'(fault_level) < LEVELS));  // R6

endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W   (VA_W),
  .LVL_W  (LVL_W),
  .LEVELS (LEVELS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_va        (req_va),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .fault_level   (fault_level)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;

  localparam int PA_W  = 40;
  localparam int PFN_W = 27;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic             rst_n;
  logic             req_valid;
  logic [63:0]      req_va;
  logic [PFN_W-1:0] req_root;
  logic             req_user, req_write;
  logic             busy, mem_req_valid;
  logic [PA_W-1:0]  mem_req_addr;
  logic             mem_rsp_valid;
  logic [63:0]      mem_rsp_data;
  logic             done, fault, fault_perm;
  logic [1:0]       fault_level;
  logic [PFN_W-1:0] res_pfn;
  logic [3:0]       res_perm;
  logic [1:0]       res_region;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_root(req_root), .req_user(req_user), .req_write(req_write),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_perm(fault_perm),
    .fault_level(fault_level), .res_pfn(res_pfn), .res_perm(res_perm),
    .res_region(res_region)
  );

  int  vectors = 0;
  int  errors  = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [PFN_W-1:0] pfn, input logic [4:0] fl);
    logic [63:0] p;
    p = 64'd0;
    p[58:32] = pfn;
    p[4:0]   = fl;
    return p;
  endfunction

  task automatic run(input logic [63:0] va, input logic [PFN_W-1:0] root,
                     input bit usr, input bit wr,
                     input logic [63:0] p0, input logic [63:0] p1, input logic [63:0] p2,
                     input int lat, input bit poke);
    logic [63:0]      ptes [3];
    logic [PA_W-1:0]  exp_addr [3];
    logic [PFN_W-1:0] base, exp_pfn;
    logic [3:0]       exp_perm;
    logic [1:0]       exp_region, exp_flvl;
    bit               exp_fault, exp_fperm, ended, gone, kern;
    int               exp_reads, reads, cycles;
    ptes[0] = p0; ptes[1] = p1; ptes[2] = p2;
    exp_fault = 0; exp_fperm = 0; exp_flvl = 0; exp_pfn = '0; exp_perm = '0;
    exp_reads = 0; gone = 0;
    for (int l = 0; l < 3; l++) exp_addr[l] = '0;
    exp_region = !va[63] ? 2'd0 : (va[62] ? 2'd1 : 2'd2);
    kern = (exp_region == 2'd2);
    if (kern) begin
      if (usr) begin exp_fault = 1; exp_fperm = 1; exp_flvl = 0; end
      exp_pfn  = va[39:13];
      exp_perm = 4'b0011;
    end else begin
      base = root;
      for (int l = 0; l < 3; l++) begin
        if (!gone) begin
          exp_addr[l] = {base, va[33 - 10*l +: 10], 3'b000};
          exp_reads = l + 1;
          if (!ptes[l][0]) begin
            exp_fault = 1; exp_fperm = 0; exp_flvl = 2'(l); gone = 1;
          end else if (l < 2) begin
            base = ptes[l][58:32];
          end else begin
            exp_pfn  = ptes[l][58:32];
            exp_perm = ptes[l][4:1];
            if (!(usr ? (wr ? exp_perm[3] : exp_perm[2])
                      : (wr ? exp_perm[1] : exp_perm[0]))) begin
              exp_fault = 1; exp_fperm = 1; exp_flvl = 2'd2;
            end
          end
        end
      end
    end

    @(negedge clk);
    req_valid = 1; req_va = va; req_root = root; req_user = usr; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);

    reads = 0; cycles = 0; ended = 0;
    while (!ended && cycles < 200) begin
      if (done || fault) begin
        ended = 1;
      end else if (mem_req_valid) begin
        if (reads < 3)
          chk(mem_req_addr == exp_addr[reads], "R4", "read address",
              64'(mem_req_addr), 64'(exp_addr[reads]));
        reads++;
        if (poke && reads == 1) begin
          // R9: a request while busy must be ignored
          req_valid = 1; req_va = 64'h8000_0000_0000_2000; req_user = 0;
        end
        repeat (lat) begin @(negedge clk); req_valid = 0; cycles++; end
        mem_rsp_valid = 1;
        mem_rsp_data  = (reads <= 3) ? ptes[reads-1] : 64'd0;
        @(negedge clk);
        mem_rsp_valid = 0;
        cycles++;
      end else begin
        @(negedge clk);
        cycles++;
      end
    end

    chk(ended, "R9", "walk ended", 64'(ended), 64'd1);
    if (kern) chk(cycles == 0, "R3", "kernel window latency", 64'(cycles), 64'd0);
    chk(reads == exp_reads, kern ? "R3" : "R5", "read count", 64'(reads), 64'(exp_reads));
    chk(fault == exp_fault, exp_fault ? "R6" : "R8", "fault pulse", 64'(fault), 64'(exp_fault));
    chk(done == !exp_fault, "R8", "done pulse", 64'(done), 64'(!exp_fault));
    chk(res_region == exp_region, "R2", "region", 64'(res_region), 64'(exp_region));
    if (exp_fault) begin
      chk(fault_perm == exp_fperm, exp_fperm ? "R7" : "R6", "fault kind",
          64'(fault_perm), 64'(exp_fperm));
      chk(fault_level == exp_flvl, exp_fperm ? "R7" : "R6", "fault level",
          64'(fault_level), 64'(exp_flvl));
    end else begin
      chk(res_pfn == exp_pfn, kern ? "R3" : "R8", "frame", 64'(res_pfn), 64'(exp_pfn));
      chk(res_perm == exp_perm, kern ? "R3" : "R8", "perm", 64'(res_perm), 64'(exp_perm));
    end
    @(negedge clk);
    chk(busy == 1'b0, "R9", "idle after end", 64'(busy), 64'd0);
    chk(!done && !fault, "R8", "end is one pulse", 64'({done, fault}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_va = '0; req_root = '0; req_user = 0; req_write = 0;
    mem_rsp_valid = 0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, fault, mem_req_valid} == 4'b0, "R1", "outputs in reset",
        64'({busy, done, fault, mem_req_valid}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, fault, mem_req_valid} == 4'b0, "R1", "outputs after reset",
        64'({busy, done, fault, mem_req_valid}), 64'd0);

    // R7 R8 R10: every leaf permission pattern, all mode/type pairs, junk in 61:43
    for (int f = 0; f < 16; f++) begin
      for (int u = 0; u < 2; u++) begin
        for (int w = 0; w < 2; w++) begin
          int n;
          logic [63:0] va;
          n = f*4 + u*2 + w;
          va = {((f % 2) != 0) ? 2'b11 : 2'b00, 19'(n * 7919),
                10'(n * 37 + 1), 10'(n * 11 + 500), 10'(1023 - n), 13'(n * 101)};
          run(va, 27'(n * 12345 + 7), u[0], w[0],
              mk(27'(n * 3 + 100), 5'b00001), mk(27'(n * 5 + 200), 5'b00001),
              mk(27'(n * 977 + 3), {4'(f), 1'b1}), 1 + (n % 3), (n % 5) == 0);
        end
      end
    end

    // R6: invalid entry at each level, both walked regions
    for (int l = 0; l < 3; l++) begin
      for (int s = 0; s < 2; s++) begin
        logic [63:0] va;
        va = {(s != 0) ? 2'b11 : 2'b01, 19'(l * 3 + 5), 43'(64'h0155_5555_5555 + l)};
        run(va, 27'(l + 1), s[0], 1'b0,
            mk(27'd11, (l == 0) ? 5'b11110 : 5'b11111),
            mk(27'd22, (l == 1) ? 5'b11110 : 5'b11111),
            mk(27'd33, (l == 2) ? 5'b11110 : 5'b11111), 2, 1'b0);
      end
    end

    // R4 R10: all-ones indices and offset
    run({2'b00, 19'h7FFFF, 43'h7FF_FFFF_FFFF}, 27'h7FFFFFF, 1'b1, 1'b1,
        mk(27'h7FFFFFF, 5'b00001), mk(27'h4000000, 5'b00001),
        mk(27'h1234567, 5'b11111), 3, 1'b0);

    // R3: kernel window, kernel mode and user mode
    for (int k = 0; k < 10; k++) begin
      logic [63:0] va;
      va = {2'b10, 62'(64'h0000_00A5_0000_1FFF * (k + 1) + 64'(k) * 64'h0FFF_0000_0000)};
      run(va, 27'(k), k >= 8, k[0], 64'd0, 64'd0, 64'd0, 1, 1'b0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule